// File: doc/BRIEF.md
# Double-Precision Compare with Condition and Status Registers

This block compares two IEEE-754 binary64 values, taken as raw 64-bit words, and records the outcome in two 32-bit registers that it owns. The outcome is a 4-bit condition nibble with one bit each for less-than, greater-than, equal and unordered. On a valid strobe, the nibble is written into one selectable 4-bit field of the condition register. It is also copied into the condition-code field of the status register.

Each NaN operand is sorted into signalling or quiet from its raw bits. The compare then sets sticky invalid-operation bits in the status register. Two modes exist. The unordered mode raises flags only for signalling NaNs. The ordered mode raises flags for any NaN and adds an invalid-compare bit, which depends on the invalid-operation trap enable input. The block only produces flags: it delivers no trap, and it does no rounding or arithmetic.

The nibble is also available combinationally, so a neighbouring stage can use it in the same cycle.

Top module: `fcmp_status_unit`

## Requirements
- R1: An operand is signalling NaN when exponent bits 62..52 are all ones, fraction bits 51..0 are nonzero and bit 51 is zero; in unordered mode such an operand makes the compare unordered and sets status bits 31, 29 and 24.
- R2: An operand is quiet NaN when bits 62..52 are all ones and bit 51 is one; in unordered mode a quiet NaN gives an unordered result and sets no status exception bit.
- R3: The nibble encodes less-than in bit 3, greater-than in bit 2, equal in bit 1 and unordered in bit 0; with a NaN operand only bit 0 is set, otherwise exactly one of bits 3..1 is set, according to signed numeric order.
- R4: Positive and negative zero compare equal, and infinities order by their sign like finite values.
- R5: In unordered mode the invalid-compare bit (status bit 19) is never set.
- R6: In ordered mode any NaN operand sets status bits 31 and 29, and a signalling NaN also sets bit 24.
- R7: In ordered mode with a NaN operand, status bit 19 is set when the trap enable input is low or either operand is quiet NaN; a signalling-only pair with the trap enabled leaves it clear.
- R8: Each compare replaces status bits 15..12 with the nibble (nibble bit 3 to status bit 15).
- R9: Each compare replaces condition-register bits [31-4k -: 4] with the nibble, where k is the field select, and leaves every other field unchanged.
- R10: Status exception bits are sticky: a compare only ORs bits in and never clears them.
- R11: With the valid strobe low, neither register changes.
- R12: Reset clears both registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Commit this cycle's compare into the registers |
| ordered_i | input | 1 | 1 selects ordered mode, 0 selects unordered mode |
| trap_en_i | input | 1 | Invalid-operation trap enable, used by the ordered rule |
| field_sel_i | input | 3 | Condition-register field index k |
| opa_i | input | 64 | First operand, raw binary64 |
| opb_i | input | 64 | Second operand, raw binary64 |
| cmp_nibble_o | output | 4 | Combinational compare nibble |
| cond_reg_o | output | 32 | Condition register |
| status_reg_o | output | 32 | Status register |

## Verification
The bench builds the block with its defaults: 64-bit operands, 32-bit registers and eight 4-bit fields. With those values every field index can be reached, including both edge fields at bits 31..28 and bits 3..0, so preservation of neighbouring fields is visible in the whole condition register. The vector order is arranged so that sticky bits from an earlier NaN case do not hide the flag that a later case must or must not raise. A mid-run reset then clears the registers so that the trap-disabled ordered rule can be checked on a clean status word.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2
  } fp_cls_e;

  // nibble bit positions
  localparam int NB_LT = 3;
  localparam int NB_GT = 2;
  localparam int NB_EQ = 1;
  localparam int NB_UN = 0;

  // status register bit positions
  localparam int ST_XSUM   = 31;
  localparam int ST_INVSUM = 29;
  localparam int ST_INVSIG = 24;
  localparam int ST_INVCMP = 19;
  localparam int ST_CC_LO  = 12;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int FP_W  = 64,
  parameter int EXP_W = 11
) (
  input  logic [FP_W-1:0] op_i,
  output fp_cls_e         cls_o,
  output logic            zero_o
);
  localparam int FRAC_W = FP_W - 1 - EXP_W;

  logic              exp_full;
  logic [FRAC_W-1:0] frac;

  assign exp_full = &op_i[FP_W-2 -: EXP_W];
  assign frac     = op_i[FRAC_W-1:0];
  assign zero_o   = ~|op_i[FP_W-2:0];

  always_comb begin
    cls_o = CLS_NUM;
    if (exp_full && frac[FRAC_W-1])
      cls_o = CLS_QNAN;
    else if (exp_full && (|frac))
      cls_o = CLS_SNAN;
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int FP_W = 64
) (
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  logic            a_zero_i,
  input  logic            b_zero_i,
  output logic            lt_o,
  output logic            gt_o,
  output logic            eq_o
);
  // map sign-magnitude onto an unsigned key that sorts in numeric order
  function automatic logic [FP_W-1:0] to_key(input logic [FP_W-1:0] x);
    if (x[FP_W-1]) return ~x;
    return {1'b1, x[FP_W-2:0]};
  endfunction

  logic [FP_W-1:0] ka, kb;

  assign ka   = to_key(a_i);
  assign kb   = to_key(b_i);
  assign eq_o = (a_zero_i && b_zero_i) || (a_i == b_i);
  assign lt_o = !eq_o && (ka < kb);
  assign gt_o = !eq_o && !lt_o;
endmodule

// File: rtl/fcmp_flag_gen.sv
module fcmp_flag_gen
  import fcmp_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             ordered_i,
  input  logic             trap_en_i,
  input  fp_cls_e          a_cls_i,
  input  fp_cls_e          b_cls_i,
  output logic [REG_W-1:0] set_o
);
  logic any_snan, any_qnan, any_nan;

  assign any_snan = (a_cls_i == CLS_SNAN) || (b_cls_i == CLS_SNAN);
  assign any_qnan = (a_cls_i == CLS_QNAN) || (b_cls_i == CLS_QNAN);
  assign any_nan  = any_snan || any_qnan;

  always_comb begin
    set_o = '0;
    if (ordered_i) begin
      if (any_nan) begin
        set_o[ST_XSUM]   = 1'b1;
        set_o[ST_INVSUM] = 1'b1;
        set_o[ST_INVCMP] = !trap_en_i || any_qnan;
      end
      set_o[ST_INVSIG] = any_snan;
    end else if (any_snan) begin
      set_o[ST_XSUM]   = 1'b1;
      set_o[ST_INVSUM] = 1'b1;
      set_o[ST_INVSIG] = 1'b1;
    end
  end
endmodule

// File: rtl/fcmp_status_unit.sv
module fcmp_status_unit
  import fcmp_pkg::*;
#(
  parameter int FP_W    = 64,
  parameter int EXP_W   = 11,
  parameter int REG_W   = 32,
  parameter int FIELD_W = $clog2(REG_W / NIB_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               ordered_i,
  input  logic               trap_en_i,
  input  logic [FIELD_W-1:0] field_sel_i,
  input  logic [FP_W-1:0]    opa_i,
  input  logic [FP_W-1:0]    opb_i,
  output logic [NIB_W-1:0]   cmp_nibble_o,
  output logic [REG_W-1:0]   cond_reg_o,
  output logic [REG_W-1:0]   status_reg_o
);
  localparam int NUM_FIELDS = REG_W / NIB_W;
  localparam logic [REG_W-1:0] CC_MASK =
    {{(REG_W-NIB_W){1'b0}}, {NIB_W{1'b1}}} << ST_CC_LO;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operand classification
  logic [FP_W-1:0] ops [2];
  fp_cls_e         cls [2];
  logic            zero [2];

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.FP_W(FP_W), .EXP_W(EXP_W)) u_cls (
      .op_i   (ops[i]),
      .cls_o  (cls[i]),
      .zero_o (zero[i])
    );
  end

  logic lt, gt, eq, unord;

  fcmp_order #(.FP_W(FP_W)) u_order (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .a_zero_i (zero[0]),
    .b_zero_i (zero[1]),
    .lt_o     (lt),
    .gt_o     (gt),
    .eq_o     (eq)
  );

  logic [REG_W-1:0] set_mask;

  fcmp_flag_gen #(.REG_W(REG_W)) u_flags (
    .ordered_i (ordered_i),
    .trap_en_i (trap_en_i),
    .a_cls_i   (cls[0]),
    .b_cls_i   (cls[1]),
    .set_o     (set_mask)
  );

  assign unord = (cls[0] != CLS_NUM) || (cls[1] != CLS_NUM);

  always_comb begin
    cmp_nibble_o        = '0;
    cmp_nibble_o[NB_UN] = unord;
    cmp_nibble_o[NB_LT] = !unord && lt;
    cmp_nibble_o[NB_GT] = !unord && gt;
    cmp_nibble_o[NB_EQ] = !unord && eq;
  end

  // next state
  logic [REG_W-1:0] cond_q, cond_d, cond_upd;
  logic [REG_W-1:0] stat_q, stat_d;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int LO = REG_W - NIB_W * (f + 1);
    assign cond_upd[LO +: NIB_W] =
      (field_sel_i == FIELD_W'(f)) ? cmp_nibble_o : cond_q[LO +: NIB_W];
  end

  always_comb begin
    cond_d = cond_q;
    stat_d = stat_q;
    if (valid_i) begin
      cond_d = cond_upd;
      stat_d = ((stat_q | set_mask) & ~CC_MASK)
             | ({{(REG_W-NIB_W){1'b0}}, cmp_nibble_o} << ST_CC_LO);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cond_q <= '0;
      stat_q <= '0;
    end else if (valid_i) begin
      cond_q <= cond_d;
      stat_q <= stat_d;
    end
  end

  assign cond_reg_o   = cond_q;
  assign status_reg_o = stat_q;
endmodule

// File: rtl/fcmp_status_unit_chk.sv
module fcmp_status_unit_chk #(
  parameter int REG_W   = 32,
  parameter int NIB_W   = 4,
  parameter int FIELD_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_i,
  input logic               ordered_i,
  input logic [FIELD_W-1:0] field_sel_i,
  input logic [NIB_W-1:0]   cmp_nibble_o,
  input logic [REG_W-1:0]   cond_reg_o,
  input logic [REG_W-1:0]   status_reg_o
);
  localparam logic [REG_W-1:0] STICKY_MASK =
    ~({{(REG_W-NIB_W){1'b0}}, {NIB_W{1'b1}}} << 12);

  // R3: nibble always has exactly one bit set
  a_r3_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmp_nibble_o) == 1);

  // R8: condition code mirrors the committed nibble
  a_r8_cc_copy: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> status_reg_o[15:12] == $past(cmp_nibble_o));

  // R9: selected field receives the nibble
  a_r9_field_write: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> cond_reg_o[(REG_W-NIB_W) - NIB_W*$past(field_sel_i) +: NIB_W]
                == $past(cmp_nibble_o));

  // R10: exception bits never fall
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_reg_o & $past(status_reg_o) & STICKY_MASK)
      == ($past(status_reg_o) & STICKY_MASK)));

  // R5: unordered mode never raises the invalid-compare bit
  a_r5_no_invcmp: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ordered_i) |=> status_reg_o[19] == $past(status_reg_o[19]));

  // R11: registers hold without a strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(cond_reg_o) && $stable(status_reg_o)));
endmodule

bind fcmp_status_unit fcmp_status_unit_chk #(
  .REG_W(REG_W), .NIB_W(fcmp_pkg::NIB_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .valid_i      (valid_i),
  .ordered_i    (ordered_i),
  .field_sel_i  (field_sel_i),
  .cmp_nibble_o (cmp_nibble_o),
  .cond_reg_o   (cond_reg_o),
  .status_reg_o (status_reg_o)
);

// File: tb/fcmp_status_unit_bench.sv
module fcmp_status_unit_bench;
  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] M1   = 64'hBFF0000000000000;
  localparam logic [63:0] M15  = 64'hBFF8000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QN   = 64'h7FF8000000000000;
  localparam logic [63:0] SN   = 64'h7FF0000000000001;
  localparam logic [63:0] SN2  = 64'hFFF4000000000000;
  localparam logic [3:0]  LT = 4'h8, GT = 4'h4, EQ = 4'h2, UN = 4'h1;
  localparam logic [31:0] F_SIG = 32'hA100_0000;  // bits 31,29,24
  localparam logic [31:0] F_INV = 32'hA000_0000;  // bits 31,29
  localparam logic [31:0] F_CMP = 32'h0008_0000;  // bit 19

  typedef struct packed {
    logic        ord;
    logic        trap;
    logic [2:0]  fld;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  nib;
    logic [31:0] flg;
  } vec_t;

  localparam int NV = 13;
  localparam logic [168:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, P1,   P2,   LT, 32'h0},          // R3 less
    {1'b0, 1'b0, 3'd1, P2,   P1,   GT, 32'h0},          // R3 greater
    {1'b0, 1'b0, 3'd2, P1,   P1,   EQ, 32'h0},          // R3 equal
    {1'b0, 1'b0, 3'd3, PZ,   NZ,   EQ, 32'h0},          // R4 zeros
    {1'b0, 1'b0, 3'd4, M1,   P1,   LT, 32'h0},          // R3 signs
    {1'b0, 1'b0, 3'd5, NINF, M1,   LT, 32'h0},          // R4 -inf
    {1'b0, 1'b0, 3'd6, PINF, P2,   GT, 32'h0},          // R4 +inf
    {1'b0, 1'b0, 3'd7, M1,   M15,  GT, 32'h0},          // R3 negatives
    {1'b0, 1'b0, 3'd0, QN,   P1,   UN, 32'h0},          // R2 quiet, no flags
    {1'b0, 1'b0, 3'd1, P1,   SN,   UN, F_SIG},          // R1 R5 signalling
    {1'b1, 1'b1, 3'd2, SN2,  P1,   UN, F_SIG},          // R6 R7 snan, trap on
    {1'b1, 1'b1, 3'd3, P1,   QN,   UN, F_INV | F_CMP},  // R7 quiet in ordered
    {1'b1, 1'b1, 3'd4, P1,   P2,   LT, 32'h0}           // R10 nothing cleared
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, ordered_i = 1'b0, trap_en_i = 1'b0;
  logic [2:0]  field_sel_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [3:0]  cmp_nibble_o;
  logic [31:0] cond_reg_o, status_reg_o;

  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] exp_cond = '0, exp_stat = '0;

  always #5 clk = ~clk;

  fcmp_status_unit u_fcmp_status_unit (
    .clk, .rst_n, .valid_i, .ordered_i, .trap_en_i, .field_sel_i,
    .opa_i, .opb_i, .cmp_nibble_o, .cond_reg_o, .status_reg_o
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // model from R8, R9, R10
  task automatic model(input logic [2:0] fld, input logic [3:0] nib, input logic [31:0] flg);
    exp_cond[28 - 4*fld +: 4] = nib;
    exp_stat = ((exp_stat | flg) & ~32'h0000F000) | ({28'h0, nib} << 12);
  endtask

  task automatic run(input vec_t v, input string tag);
    @(negedge clk);
    ordered_i = v.ord; trap_en_i = v.trap; field_sel_i = v.fld;
    opa_i = v.a; opb_i = v.b; valid_i = 1'b1;
    #1;
    check({tag, " nibble"}, {28'h0, cmp_nibble_o}, {28'h0, v.nib});
    model(v.fld, v.nib, v.flg);
    @(negedge clk);
    valid_i = 1'b0;
    check({tag, " R9 cond"}, cond_reg_o, exp_cond);
    check({tag, " R8/R10 status"}, status_reg_o, exp_stat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 cond at reset", cond_reg_o, 32'h0);
    check("R12 status at reset", status_reg_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) run(vec_t'(VEC[i]), $sformatf("vec%0d", i));

    // R11: strobe low, different operands, nothing changes
    @(negedge clk);
    ordered_i = 1'b1; trap_en_i = 1'b0; field_sel_i = 3'd0;
    opa_i = SN; opb_i = QN; valid_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 cond hold", cond_reg_o, exp_cond);
    check("R11 status hold", status_reg_o, exp_stat);

    // R12: reset mid-run clears both
    rst_n = 1'b0;
    #1;
    check("R12 cond cleared", cond_reg_o, 32'h0);
    check("R12 status cleared", status_reg_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_cond = '0; exp_stat = '0;

    // R7: ordered, trap off, signalling only -> invalid-compare set
    run('{ord:1'b1, trap:1'b0, fld:3'd7, a:SN, b:P1, nib:UN, flg:F_SIG | F_CMP}, "R7 trap off");
    // R6: ordered non-NaN adds no flags, R4 zeros equal
    run('{ord:1'b1, trap:1'b0, fld:3'd0, a:NZ, b:PZ, nib:EQ, flg:32'h0}, "R6 ordered numbers");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule